// File: doc/BRIEF.md
# Mode-Switched Serial Load Register

This block is the serial configuration front end of a multi-channel LED driver. It runs on one system clock. It samples a slow serial clock, a data bit, a latch strobe and a mode select through synchronizer flops. On each rising edge of the serial clock it shifts one bit into a shift register, most significant bit first. The bit leaving the far end is driven on the serial output, so several devices can be chained. The serial output taps the shift register at a point that depends on the mode: 96 bits deep for per-channel current trim and 192 bits deep for per-channel brightness.

A rising edge of the latch strobe copies the shift register into one of two configuration registers. In trim mode the target is the 96-bit trim register (six bits per channel). In brightness mode the target is the 192-bit brightness register (twelve bits per channel). Channel 15 arrives first in both cases. After a brightness transfer the shift register is overwritten with a 192-bit status word, which shifts out while the next brightness frame shifts in. The status word holds the open-LED flags, the thermal flag and a copy of the trim register.

The first brightness transfer after a trim transfer completes only on the next serial clock edge. The mode select is frozen while the strobe is high. An attempt to change it during that time sets a sticky error flag.

Top module: `mode_serial_loader`

## Requirements
- R1: In brightness mode (modeIn low) the serial output presents the bit that was shifted in 192 serial-clock rises earlier.
- R2: In trim mode (modeIn high) the serial output presents the bit that was shifted in 96 serial-clock rises earlier.
- R3: A latch-strobe rise in trim mode writes the last 96 shifted bits to dcOut. The earliest of those bits lands in dcOut[95], so channel 15 occupies dcOut[95:90] and channel 0 occupies dcOut[5:0].
- R4: A latch-strobe rise in brightness mode writes the last 192 shifted bits to gsOut. The earliest of those bits lands in gsOut[191], so channel c occupies gsOut[12c+11:12c].
- R5: dcOut and gsOut keep their values at all times other than a transfer aimed at them. A transfer to one register leaves the other unchanged.
- R6: Each brightness transfer replaces the shift register with the status word. In the order the bits are sent, the word is: lodFlags[15] down to lodFlags[0], then tefFlag, then seven zero bits, then dcOut[95] down to dcOut[0], then 72 zero bits. The first status bit is on the serial output before the next serial-clock rise.
- R7: Each following serial-clock rise in brightness mode presents the next status bit, while new data enters at the other end.
- R8: The first brightness-mode strobe after a trim transfer does not change gsOut. The next serial-clock rise shifts in one more bit, then writes the resulting 192 bits to gsOut and loads the status word. Later strobes transfer immediately.
- R9: A change of modeIn while the synchronized strobe is high is ignored: the previous mode stays in force until the strobe falls. The change sets protoErr, which stays set until reset.
- R10: After reset, dcOut, gsOut, soutOut and protoErr are all zero.
- R11: All four serial control inputs pass through a two-stage synchronizer. An edge takes effect on the third system-clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial shift clock, sampled |
| sinIn | input | 1 | Serial data in |
| xlatIn | input | 1 | Latch strobe, acts on its rising edge |
| modeIn | input | 1 | 1 = trim (96-bit) mode, 0 = brightness (192-bit) mode |
| lodFlags | input | 16 | Open-LED flags per channel, captured into the status word |
| tefFlag | input | 1 | Thermal flag, captured into the status word |
| soutOut | output | 1 | Serial data out for chaining and readback |
| dcOut | output | 96 | Trim register |
| gsOut | output | 192 | Brightness register |
| protoErr | output | 1 | Sticky flag for a mode change while the strobe is high |

## Verification
The deferred transfer is the hardest state to reach from the ports. It only exists between a brightness-mode strobe that follows a trim transfer and the next serial-clock rise. The stimulus loads trim data, switches mode and sends a full frame. It then strobes and checks that gsOut is unchanged. Next it sends one more bit and checks that gsOut holds the shifted frame with that bit as its LSB. It finally shifts the status word out and checks that its trim field is the value just loaded.

// File: rtl/slr_pkg.sv
package slr_pkg;

  // Strobes issued by the control path to the datapath for one system clock.
  typedef struct packed {
    logic shift;     // shift sinBit into the LSB end
    logic sinBit;    // synchronized serial data
    logic wrDc;      // copy shift register into trim register
    logic wrGs;      // copy (possibly shifted) contents into brightness register
    logic ldStatus;  // overwrite shift register with the status word
    logic modeDc;    // active mode: 1 = trim, 0 = brightness
  } slrStrobe_t;

endpackage

// File: rtl/slr_ctrl.sv
module slr_ctrl
  import slr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       sinIn,
  input  logic       xlatIn,
  input  logic       modeIn,
  output slrStrobe_t strb,
  output logic       protoErr
);

  localparam int LAST = SYNC_STAGES - 1;

  // Bit order per stage: {mode, xlat, sin, sclk}
  logic [3:0] syncReg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncReg[i] <= '0;
    end else begin
      syncReg[0] <= {modeIn, xlatIn, sinIn, sclkIn};
      for (int i = 1; i < SYNC_STAGES; i++) syncReg[i] <= syncReg[i-1];
    end
  end

  logic sclkS, sinS, xlatS, modeS;
  assign sclkS = syncReg[LAST][0];
  assign sinS  = syncReg[LAST][1];
  assign xlatS = syncReg[LAST][2];
  assign modeS = syncReg[LAST][3];

  logic sclkPrev, xlatPrev;
  logic modeEff, needExtra, armed, errReg;

  logic sclkRise, xlatRise, gsStrobe, commit;
  assign sclkRise = sclkS & ~sclkPrev;
  assign xlatRise = xlatS & ~xlatPrev;
  assign gsStrobe = xlatRise & ~modeEff & ~armed;
  assign commit   = sclkRise & armed & ~modeEff;

  always_comb begin
    strb          = '0;
    strb.sinBit   = sinS;
    strb.modeDc   = modeEff;
    strb.shift    = sclkRise;
    strb.wrDc     = xlatRise & modeEff;
    strb.wrGs     = (gsStrobe & ~needExtra) | commit;
    strb.ldStatus = (gsStrobe & ~needExtra) | commit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      xlatPrev  <= 1'b0;
      modeEff   <= 1'b0;
      needExtra <= 1'b0;
      armed     <= 1'b0;
      errReg    <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      xlatPrev <= xlatS;
      if (!xlatS) modeEff <= modeS;
      if (xlatS && (modeS != modeEff)) errReg <= 1'b1;
      if (xlatRise && modeEff) begin
        needExtra <= 1'b1;
        armed     <= 1'b0;
      end else if (gsStrobe && needExtra) begin
        needExtra <= 1'b0;
        armed     <= 1'b1;
      end else if (commit) begin
        armed <= 1'b0;
      end
    end
  end

  assign protoErr = errReg;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrDc && strb.wrGs)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R9

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (xlatS && $past(xlatS)) |-> $stable(strb.modeDc)); // R9

endmodule

// File: rtl/slr_datapath.sv
module slr_datapath
  import slr_pkg::*;
#(
  parameter int CH      = 16,
  parameter int DC_BITS = 6,
  parameter int GS_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  slrStrobe_t              strb,
  input  logic [CH-1:0]           lodFlags,
  input  logic                    tefFlag,
  output logic                    sout,
  output logic [CH*DC_BITS-1:0]   dcReg,
  output logic [CH*GS_BITS-1:0]   gsReg
);

  localparam int DC_LEN     = CH * DC_BITS;
  localparam int GS_LEN     = CH * GS_BITS;
  localparam int FLAG_FIELD = ((CH + 1 + 7) / 8) * 8;
  localparam int DC_TOP     = GS_LEN - 1 - FLAG_FIELD;

  logic [GS_LEN-1:0] shiftReg, shifted, statusWord;

  assign shifted = {shiftReg[GS_LEN-2:0], strb.sinBit};

  always_comb begin
    statusWord                     = '0;
    statusWord[GS_LEN-1 -: CH]     = lodFlags;
    statusWord[GS_LEN-1-CH]        = tefFlag;
    statusWord[DC_TOP -: DC_LEN]   = dcReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      dcReg    <= '0;
      gsReg    <= '0;
    end else begin
      if (strb.ldStatus)   shiftReg <= statusWord;
      else if (strb.shift) shiftReg <= shifted;
      if (strb.wrDc) dcReg <= shiftReg[DC_LEN-1:0];
      if (strb.wrGs) gsReg <= strb.shift ? shifted : shiftReg;
    end
  end

  assign sout = strb.modeDc ? shiftReg[DC_LEN-1] : shiftReg[GS_LEN-1];

  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDc |=> $stable(dcReg)); // R5

  AST_GS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrGs |=> $stable(gsReg)); // R5

  AST_DC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDc |=> dcReg == $past(shiftReg[DC_LEN-1:0])); // R3

  AST_STATUS_MSB: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldStatus |=> shiftReg[GS_LEN-1] == $past(lodFlags[CH-1])); // R6

endmodule

// File: rtl/mode_serial_loader.sv
module mode_serial_loader
  import slr_pkg::*;
#(
  parameter int CH          = 16,
  parameter int DC_BITS     = 6,
  parameter int GS_BITS     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclkIn,
  input  logic                  sinIn,
  input  logic                  xlatIn,
  input  logic                  modeIn,
  input  logic [CH-1:0]         lodFlags,
  input  logic                  tefFlag,
  output logic                  soutOut,
  output logic [CH*DC_BITS-1:0] dcOut,
  output logic [CH*GS_BITS-1:0] gsOut,
  output logic                  protoErr
);

  slrStrobe_t strb;

  slr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkIn   (sclkIn),
    .sinIn    (sinIn),
    .xlatIn   (xlatIn),
    .modeIn   (modeIn),
    .strb     (strb),
    .protoErr (protoErr)
  );

  slr_datapath #(.CH(CH), .DC_BITS(DC_BITS), .GS_BITS(GS_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lodFlags (lodFlags),
    .tefFlag  (tefFlag),
    .sout     (soutOut),
    .dcReg    (dcOut),
    .gsReg    (gsOut)
  );

endmodule

// File: tb/mode_serial_loader_tb.sv
module mode_serial_loader_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, sinIn = 1'b0, xlatIn = 1'b0, modeIn = 1'b0;
  logic [15:0] lodFlags = 16'hA5C3;
  logic tefFlag = 1'b1;
  logic soutOut, protoErr;
  logic [95:0] dcOut;
  logic [191:0] gsOut;

  always #4 clk = ~clk; // 125 MHz

  mode_serial_loader u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sinIn(sinIn), .xlatIn(xlatIn),
    .modeIn(modeIn), .lodFlags(lodFlags), .tefFlag(tefFlag), .soutOut(soutOut),
    .dcOut(dcOut), .gsOut(gsOut), .protoErr(protoErr)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  bit h0 [4], h1 [4], h2 [4], h3 [4]; // {sclk, sin, xlat, mode}
  bit q [$];
  logic [95:0]  mDc;
  logic [191:0] mGs;
  bit mMode, mNeed, mArmed, mErr;

  function automatic void loadStatus();
    q.delete();
    for (int c = 15; c >= 0; c--) q.push_back(lodFlags[c]);
    q.push_back(tefFlag);
    for (int k = 0; k < 7; k++) q.push_back(1'b0);
    for (int k = 95; k >= 0; k--) q.push_back(mDc[k]);
    while (q.size() < 192) q.push_back(1'b0);
  endfunction

  function automatic void modelReset();
    q.delete();
    for (int k = 0; k < 192; k++) q.push_back(1'b0);
    mDc = '0; mGs = '0; mMode = 0; mNeed = 0; mArmed = 0; mErr = 0;
    for (int k = 0; k < 4; k++) begin h0[k] = 0; h1[k] = 0; h2[k] = 0; h3[k] = 0; end
  endfunction

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit sr, xr;
      h3 = h2; h2 = h1; h1 = h0;
      h0[0] = sclkIn; h0[1] = sinIn; h0[2] = xlatIn; h0[3] = modeIn;
      sr = h2[0] && !h3[0];
      xr = h2[2] && !h3[2];
      if (sr) begin
        q.push_back(h2[1]);
        void'(q.pop_front());
        if (mArmed && !mMode) begin
          for (int k = 0; k < 192; k++) mGs[191-k] = q[k];
          loadStatus();
          mArmed = 0;
        end
      end
      if (xr) begin
        if (mMode) begin
          for (int k = 0; k < 96; k++) mDc[95-k] = q[96+k];
          mNeed = 1; mArmed = 0;
        end else if (!mArmed) begin
          if (mNeed) begin mNeed = 0; mArmed = 1; end
          else begin
            for (int k = 0; k < 192; k++) mGs[191-k] = q[k];
            loadStatus();
          end
        end
      end
      if (h2[2] && (h2[3] != mMode)) mErr = 1;
      if (!h2[2]) mMode = h2[3];
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if (soutOut !== (mMode ? q[96] : q[0])) begin
        mismatched++;
        $display("FAIL R1 model sout act=%b exp=%b t=%0t", soutOut, mMode ? q[96] : q[0], $time);
      end
      if (dcOut !== mDc) begin
        mismatched++;
        $display("FAIL R3 model dcOut act=%h exp=%h", dcOut, mDc);
      end
      if (gsOut !== mGs) begin
        mismatched++;
        $display("FAIL R4 model gsOut act=%h exp=%h", gsOut, mGs);
      end
      if (protoErr !== mErr) begin
        mismatched++;
        $display("FAIL R9 model protoErr act=%b exp=%b", protoErr, mErr);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // sends w[n-1] first; rx[n-1-k] is soutOut just before the k-th rise
  task automatic sendWord(input logic [191:0] w, input int n, output logic [191:0] rx);
    rx = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sinIn = w[n-1-k]; sclkIn = 1'b0;
      waitClk(4);
      rx[n-1-k] = soutOut;
      sclkIn = 1'b1;
      waitClk(4);
    end
    @(negedge clk); sclkIn = 1'b0;
    waitClk(4);
  endtask

  task automatic pulseXlat();
    @(negedge clk); xlatIn = 1'b1;
    waitClk(5);
    xlatIn = 1'b0;
    waitClk(5);
  endtask

  task automatic setMode(input logic m);
    @(negedge clk); modeIn = m;
    waitClk(5);
  endtask

  function automatic logic [191:0] pattern(input int seed);
    logic [191:0] v;
    for (int i = 0; i < 192; i++) v[i] = ((i * seed + seed / 3 + i / 5) % 3) == 1;
    return v;
  endfunction

  function automatic logic [191:0] statusExp(input logic [95:0] dc);
    logic [191:0] s = '0;
    s[191:176] = lodFlags;
    s[175]     = tefFlag;
    s[167:72]  = dc;
    return s;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    waitClk(150000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [191:0] rx, a, b, c, d, f, g, h, k;
    a = pattern(7);  b = pattern(11); c = pattern(13); d = pattern(17);
    f = pattern(19); g = pattern(23); h = pattern(29); k = pattern(31);
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    // R10: reset state
    check("R10 dcOut", {96'd0, dcOut}, '0);
    check("R10 gsOut", gsOut, '0);
    check("R10 sout/err", {190'd0, soutOut, protoErr}, '0);

    // R4: brightness load
    sendWord(a, 192, rx);
    pulseXlat();
    check("R4 gsOut after latch", gsOut, a);
    check("R5 dcOut untouched", {96'd0, dcOut}, '0);

    // R6, R7: status readback while next frame shifts in
    sendWord(b, 192, rx);
    check("R6/R7 status readback", rx, statusExp(96'd0));
    pulseXlat();
    check("R4 second latch", gsOut, b);

    // R2: trim mode is 96 deep
    setMode(1'b1);
    sendWord(c, 96, rx);
    sendWord(d, 96, rx);
    check("R2 96-bit delay", {96'd0, rx[95:0]}, {96'd0, c[95:0]});
    pulseXlat();
    check("R3 dcOut", {96'd0, dcOut}, {96'd0, d[95:0]});
    check("R5 gsOut kept", gsOut, b);

    // R8: deferred first brightness transfer after trim
    setMode(1'b0);
    sendWord(f, 192, rx);
    pulseXlat();
    check("R8 gsOut unchanged at strobe", gsOut, b);
    sendWord(192'd1, 1, rx);
    check("R8 gsOut after extra clock", gsOut, {f[190:0], 1'b1});
    sendWord(g, 192, rx);
    check("R6 status carries trim", rx, statusExp(d[95:0]));
    pulseXlat();
    check("R8 later strobe immediate", gsOut, g);

    // R1: brightness mode is 192 deep
    sendWord(h, 192, rx);
    sendWord(k, 192, rx);
    check("R1 192-bit delay", rx, h);

    // R9: mode change while strobe high
    @(negedge clk); xlatIn = 1'b1;
    waitClk(5);
    modeIn = 1'b1;
    waitClk(5);
    modeIn = 1'b0;
    waitClk(5);
    xlatIn = 1'b0;
    waitClk(6);
    check("R9 protoErr set", {191'd0, protoErr}, 192'd1);
    check("R9 dcOut unchanged", {96'd0, dcOut}, {96'd0, d[95:0]});
    check("R9 latch used old mode", gsOut, k);
    sendWord(a, 20, rx);
    check("R9 protoErr sticky", {191'd0, protoErr}, 192'd1);

    // R11: strobe acts on the third clock edge
    @(negedge clk); xlatIn = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 no transfer after two edges", gsOut, k);
    @(negedge clk);
    check("R11 transfer on third edge", {172'd0, gsOut[19:0]}, {172'd0, a[19:0]});
    xlatIn = 1'b0;
    waitClk(6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule